// File: doc/BRIEF.md
# SAR Conversion Sequencer with Split-Array Control

This block is the digital sequencer of a 12-bit successive-approximation converter. The converter's DAC is made of two capacitor arrays of equal size, six elements each. The sequencer runs each conversion as a fixed frame of 14 clock periods:

- one period in which the input is sampled,
- twelve trial periods, one per bit, from the top bit down,
- one end-of-conversion period in which the code is handed out with a single-cycle strobe.

In each trial the sequencer sets the bit under test and lets the comparator evaluate during the high half of the clock. It reads the decision at the falling edge and clears the bit before the next trial if the input is below the DAC level. The upper six bits of the running code drive the upper array and the lower six drive the lower array.

A frame begins when `start` is seen high while idle. If `start` is still high in the end-of-conversion period, the next frame follows with no gap, which gives one result every 14 clocks. The analog array, the comparator and clock generation sit outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: Asserting `rst_n` low clears at once, without a clock, `sample_o`, `eval_o`, `done_o`, both array control buses and `result_o` to 0, and leaves the sequencer idle.
- R2: While idle with `start` low, all outputs except `result_o` stay 0. A rising clock edge with `start` high while idle makes the next period the sample period, in which `sample_o` is 1 for exactly that one period.
- R3: A frame is exactly 14 periods: sample, twelve trials, end of conversion. `done_o` is 1 only in the 14th period, for one cycle.
- R4: At the start of the trial for bit b (b = 11 in period 2 down to b = 0 in period 13), the code has bit b at 1, all bits below b at 0, and all bits above b at their resolved values.
- R5: `cmp_dec` is sampled at the falling clock edge in the middle of each trial. The value 1 means the input is at or above the DAC level and keeps bit b. The value 0 clears bit b at the next rising edge.
- R6: `msb_ctl_o[i]` carries code bit 6+i and `lsb_ctl_o[i]` carries code bit i, for i = 0..5.
- R7: `eval_o` is 1 during the high half of each trial period and 0 in its low half. It is 0 in the sample period, the end-of-conversion period and while idle.
- R8: `result_o` loads the fully resolved code so that it is valid in the end-of-conversion period. At all other times it holds its previous value.
- R9: While a frame is running, `start` has no effect. If `start` is 1 in the end-of-conversion period, the following period is a new sample period; otherwise the sequencer goes idle.
- R10: Both array control buses are 0 in the sample period and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request a conversion frame |
| cmp_dec | input | 1 | Comparator decision, 1 = input at or above DAC level |
| sample_o | output | 1 | Input sampling switch control |
| eval_o | output | 1 | Comparator evaluate phase (0 = precharge) |
| msb_ctl_o | output | 6 | Upper array element controls (code bits 11..6) |
| lsb_ctl_o | output | 6 | Lower array element controls (code bits 5..0) |
| result_o | output | 12 | Converted code |
| done_o | output | 1 | One-cycle end-of-conversion strobe |

## Verification
On every cycle the assertions check the following:
- the frame order: a start while idle leads to sampling, and a busy frame runs only into trials or the end period;
- the array controls are zero while sampling;
- the top bit is set in the first trial;
- resolved upper bits never move;
- a low decision clears the bit under test;
- the done strobe lasts one cycle, and the result stays still outside it.

Only the bench scenarios can show the rest:
- the full code is correct for every one of the 4096 input levels against an ideal comparator;
- the exact period in which done rises;
- the half-period shape of the evaluate signal;
- back-to-back framing;
- the asynchronous clear in the middle of a frame.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Kind of the current frame period
  typedef enum logic [1:0] {
    PK_IDLE   = 2'd0,
    PK_SAMPLE = 2'd1,
    PK_TRIAL  = 2'd2,
    PK_EOC    = 2'd3
  } period_kind_t;

endpackage

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output period_kind_t                  kind,
  output logic [$clog2(N_BITS)-1:0]     bit_idx,
  output logic                          last_trial
);

  localparam int FRAME = N_BITS + 2;
  localparam int CW    = $clog2(FRAME);
  localparam int IW    = $clog2(N_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          st_en;

  // next-state logic
  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    st_en  = 1'b1;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        cnt_n  = '0;
      end else begin
        st_en = 1'b0;
      end
    end else if (cnt_q == LAST) begin
      cnt_n = '0;
      if (!start) begin
        busy_n = 1'b0;
      end
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  // period decode
  always_comb begin
    if (!busy_q)              kind = PK_IDLE;
    else if (cnt_q == '0)     kind = PK_SAMPLE;
    else if (cnt_q == LAST)   kind = PK_EOC;
    else                      kind = PK_TRIAL;
  end

  logic [CW-1:0] idx_full;
  assign idx_full   = CW'(N_BITS) - cnt_q;
  assign bit_idx    = (kind == PK_TRIAL) ? idx_full[IW-1:0] : '0;
  assign last_trial = (kind == PK_TRIAL) && (cnt_q == CW'(N_BITS));

  AST_START_TO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_IDLE && start) |=> (kind == PK_SAMPLE)); // R2

  AST_BUSY_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_TRIAL) |=> (kind == PK_TRIAL || kind == PK_EOC)); // R9

  AST_SAMPLE_TO_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_SAMPLE) |=> (kind == PK_TRIAL)); // R3

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_EOC && start) |=> (kind == PK_SAMPLE)); // R9

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  period_kind_t                  kind,
  input  logic [$clog2(N_BITS)-1:0]     bit_idx,
  input  logic                          cmp_dec,
  output logic [N_BITS-1:0]             code,
  output logic [N_BITS-1:0]             resolved
);

  localparam logic [N_BITS-1:0] TOP_ONE = {1'b1, {(N_BITS-1){1'b0}}};

  logic [N_BITS-1:0] code_q, code_n;
  logic              code_en;
  logic              dec_q;
  logic              dec_en;
  logic [N_BITS-1:0] bit_mask;

  // decision capture at mid-period (falling edge)
  assign dec_en = (kind == PK_TRIAL);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= 1'b0;
    end else if (dec_en) begin
      dec_q <= cmp_dec;
    end
  end

  assign bit_mask = N_BITS'(1) << bit_idx;
  assign resolved = dec_q ? code_q : (code_q & ~bit_mask);

  // next-code logic
  always_comb begin
    code_en = (kind != PK_IDLE);
    unique case (kind)
      PK_SAMPLE: code_n = TOP_ONE;
      PK_TRIAL:  code_n = resolved | (bit_mask >> 1);
      default:   code_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_n;
    end
  end

  assign code = code_q;

  // bits at or above b+2 must not move between consecutive trials
  logic [N_BITS+1:0] low_fill;
  logic [N_BITS-1:0] upper_mask;
  always_comb begin
    low_fill   = ((N_BITS+2)'(1) << (32'(bit_idx) + 2)) - (N_BITS+2)'(1);
    upper_mask = ~low_fill[N_BITS-1:0];
  end

  AST_FIRST_TRIAL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_SAMPLE) |=> (code_q == TOP_ONE)); // R4

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_TRIAL && $past(kind == PK_TRIAL))
      |-> (((code_q ^ $past(code_q)) & upper_mask) == '0)); // R4

  AST_LOW_DEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_TRIAL && !dec_q) |=> (code_q[$past(bit_idx)] == 1'b0)); // R5

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int N_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [N_BITS-1:0] din,
  output logic [N_BITS-1:0] result,
  output logic              done
);

  logic [N_BITS-1:0] result_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (load) begin
      result_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= load;
    end
  end

  assign result = result_q;
  assign done   = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(result_q)); // R8

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int HALF_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  cmp_dec,
  output logic                  sample_o,
  output logic                  eval_o,
  output logic [HALF_W-1:0]     msb_ctl_o,
  output logic [HALF_W-1:0]     lsb_ctl_o,
  output logic [2*HALF_W-1:0]   result_o,
  output logic                  done_o
);

  localparam int N_BITS = 2 * HALF_W;
  localparam int IW     = $clog2(N_BITS);

  period_kind_t       kind;
  logic [IW-1:0]      bit_idx;
  logic               last_trial;
  logic [N_BITS-1:0]  code;
  logic [N_BITS-1:0]  resolved;

  sar_frame_ctl #(.N_BITS(N_BITS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .kind       (kind),
    .bit_idx    (bit_idx),
    .last_trial (last_trial)
  );

  sar_trial_reg #(.N_BITS(N_BITS)) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .bit_idx  (bit_idx),
    .cmp_dec  (cmp_dec),
    .code     (code),
    .resolved (resolved)
  );

  sar_result_reg #(.N_BITS(N_BITS)) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (last_trial),
    .din    (resolved),
    .result (result_o),
    .done   (done_o)
  );

  // split the running code across the two array halves
  for (genvar gi = 0; gi < HALF_W; gi++) begin : g_split
    assign msb_ctl_o[gi] = code[HALF_W + gi];
    assign lsb_ctl_o[gi] = code[gi];
  end

  assign sample_o = (kind == PK_SAMPLE);
  // evaluate during the high half of a trial, precharge in the low half
  assign eval_o   = (kind == PK_TRIAL) & clk;

  AST_SAMPLE_CTL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (msb_ctl_o == '0 && lsb_ctl_o == '0 && !done_o)); // R10

endmodule

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 12;
  localparam int HW         = 6;

  // stimulus/expected pairs: {input level, expected result}
  localparam logic [23:0] VEC [16] = '{
    {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h800, 12'h800}, {12'h7FF, 12'h7FF},
    {12'h001, 12'h001}, {12'hFFE, 12'hFFE}, {12'h555, 12'h555}, {12'hAAA, 12'hAAA},
    {12'h03F, 12'h03F}, {12'hFC0, 12'hFC0}, {12'h040, 12'h040}, {12'h03E, 12'h03E},
    {12'h821, 12'h821}, {12'h7C0, 12'h7C0}, {12'h123, 12'h123}, {12'hEDC, 12'hEDC}
  };

  logic            clk   = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NB-1:0]   vin_r = '0;
  logic            cmp_dec;
  logic            sample_o, eval_o, done_o;
  logic [HW-1:0]   msb_ctl_o, lsb_ctl_o;
  logic [NB-1:0]   result_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator: 1 when input at or above DAC level
  assign cmp_dec = (vin_r >= {msb_ctl_o, lsb_ctl_o});

  sar_seq_top #(.HALF_W(HW)) i_sar_seq_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmp_dec   (cmp_dec),
    .sample_o  (sample_o),
    .eval_o    (eval_o),
    .msb_ctl_o (msb_ctl_o),
    .lsb_ctl_o (lsb_ctl_o),
    .result_o  (result_o),
    .done_o    (done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  // Called in the sample period (quarter period after the edge).
  // Leaves the bench in the end-of-conversion period.
  task automatic conv(input int vin, input int exp, input bit detail);
    vin_r = NB'(vin);
    if (detail) begin
      check("R10 controls zero in sample", {msb_ctl_o, lsb_ctl_o}, 0);
      check("R7 eval low in sample", eval_o, 0);
    end
    for (int k = 1; k <= NB; k++) begin
      tick();
      if (k == NB) check("R3 no early done", done_o, 0);
      if (detail) begin
        int b;
        int e;
        b = NB - k;
        e = (exp & ~((1 << (b + 1)) - 1)) | (1 << b);
        check("R4 R5 trial code", {msb_ctl_o, lsb_ctl_o}, e);
        check("R6 upper half", msb_ctl_o, e >> HW);
        check("R6 lower half", lsb_ctl_o, e & 63);
        check("R7 eval high first half", eval_o, 1);
        check("R2 sample low in trial", sample_o, 0);
        #(CLK_PERIOD/2);
        check("R7 eval low second half", eval_o, 0);
      end
    end
    tick();
    check("R3 done in 14th period", done_o, 1);
    check("R8 result in end period", result_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    n_chk++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD*2 + CLK_PERIOD/4);
    check("R1 sample reset", sample_o, 0);
    check("R1 done reset", done_o, 0);
    check("R1 result reset", result_o, 0);
    check("R1 controls reset", {msb_ctl_o, lsb_ctl_o}, 0);
    rst_n = 1'b1;

    // R2: idle without start
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R2 idle sample", sample_o, 0);
      check("R10 idle controls", {msb_ctl_o, lsb_ctl_o}, 0);
      check("R7 idle eval", eval_o, 0);
    end
    start = 1'b1;
    tick();
    check("R2 sample after start", sample_o, 1);

    // table of vectors, back to back
    foreach (VEC[i]) begin
      conv(int'(VEC[i][23:12]), int'(VEC[i][11:0]), 1'b1);
      tick();
      check("R9 back-to-back sample", sample_o, 1);
      check("R3 done single cycle", done_o, 0);
    end

    // exhaustive sweep of every input level
    for (int v = 0; v < (1 << NB); v++) begin
      conv(v, v, 1'b0);
      if (v == (1 << NB) - 1) start = 1'b0;
      tick();
      if (v != (1 << NB) - 1) check("R9 back-to-back sample", sample_o, 1);
    end

    // idle after frame with start low, result held
    check("R9 idle after end", sample_o, 0);
    for (int i = 0; i < 4; i++) begin
      check("R8 result held while idle", result_o, 4095);
      check("R10 idle controls", {msb_ctl_o, lsb_ctl_o}, 0);
      check("R3 done low while idle", done_o, 0);
      tick();
    end

    // start dropped and pulsed during a frame: frame unaffected
    start = 1'b1;
    tick();
    check("R2 sample after start", sample_o, 1);
    start = 1'b0;
    fork
      conv(12'h5A3, 12'h5A3, 1'b1);
      begin
        #(CLK_PERIOD*5);
        start = 1'b1;
        #(CLK_PERIOD);
        start = 1'b0;
      end
    join
    tick();
    check("R9 start mid-frame ignored, idle", sample_o, 0);
    check("R8 result held", result_o, 12'h5A3);

    // asynchronous reset in the middle of a frame
    start = 1'b1;
    tick();
    vin_r = 12'hFFF;
    tick();
    tick();
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async clear controls", {msb_ctl_o, lsb_ctl_o}, 0);
    check("R1 async clear result", result_o, 0);
    check("R1 async clear eval", eval_o, 0);
    check("R1 async clear sample", sample_o, 0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 idle after reset", sample_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule